// File: doc/BRIEF.md
# Sector Write Sequencer

This block runs the write phase of one sector once an upstream search has located the matching address field. Starting from that event it counts byte times, asks the host for the first data byte and confirms that the byte arrived inside a fixed window. If the byte is missing, the block abandons the sector before emitting anything. If the byte arrived, it produces the complete on-disk image of the data field one byte per byte time: a gap of zero bytes, three sync bytes, a data mark, the payload, a CRC-16 and a trailing byte.

The host side is a data register written through a one-cycle strobe, plus a data-request output. The block raises the request whenever it needs the next payload byte and drops it when the register is written. If a payload byte is not supplied in time, the block writes zero in its place and records a lost-data condition.

The byte stream leaves as a valid strobe paired with a byte. The strobe only fires on a byte-time tick, which is an input, so the pacing can be set to any rate. Encoding for the medium, the address search and the drive itself lie outside the block.

Top module: `sector_write_seq`

## Requirements
- R1: After reset `drq`, `busy`, `out_valid`, `done`, `next_sector` and `lost_data` are all 0.
- R2: `drq` rises with the 9th `byte_tick` after `start`. A `byte_tick` in the same cycle as `start` is not counted.
- R3: If `host_wr` has not occurred while `drq` was high by the 8th `byte_tick` after `drq` rose, then `done` pulses on that tick, `lost_data` becomes 1 and no `out_valid` is ever produced for that sector.
- R4: Otherwise the first output byte comes on the 12th tick after that check (tick 29 after `start`). The output is then 12 bytes of 0x00, then 3 bytes of 0xA1, then a mark byte. The mark is 0xF8 when `deleted_mark`=1 and 0xFB when it is 0. These inputs are sampled at `start`.
- R5: The payload length is 128 << `size_code` (128, 256, 512 or 1024 bytes). A sector therefore emits exactly 16 + length + 3 bytes.
- R6: Payload bytes appear in the order the host wrote them. A host write while `drq` is high drops `drq`. `drq` is raised again at the mark tick and at each payload tick, except that it is not raised when only the final payload byte remains. A full sector therefore gives exactly length rising edges of `drq`.
- R7: If no host write has arrived when a payload byte is needed, 0x00 is emitted in its place and `lost_data` is set. `lost_data` clears only at the next `start`.
- R8: After the payload come the CRC high byte, the CRC low byte and then 0xFE. The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, processed MSB first, computed over A1 A1 A1, the mark and the payload. `drq` is 0 throughout these three bytes.
- R9: On the 0xFE tick the block goes idle. If `multi_sector`=0, `done` pulses. If `multi_sector`=1, `next_sector` pulses instead, telling the owner to advance the sector number and search again.
- R10: `cancel` returns the block to idle in the next cycle with `drq` at 0. After that there is no further output and no `done`. Bytes already emitted are not retracted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_tick | input | 1 | One-cycle pulse per byte time |
| start | input | 1 | Matching address field found; begins the sequence |
| cancel | input | 1 | A new command replaces this write; stop at once |
| deleted_mark | input | 1 | Selects mark 0xF8 (1) or 0xFB (0) |
| multi_sector | input | 1 | Continue to the next sector after this one |
| size_code | input | 2 | Payload length code, 128 << code bytes |
| host_wr | input | 1 | Host writes the data register |
| host_data | input | 8 | Value written to the data register |
| drq | output | 1 | Data request to the host |
| out_valid | output | 1 | A byte is emitted this tick |
| out_byte | output | 8 | Emitted byte |
| busy | output | 1 | A sector sequence is in progress |
| lost_data | output | 1 | A host byte was missing |
| done | output | 1 | Command end pulse (interrupt source) |
| next_sector | output | 1 | Multi-sector continuation pulse |

## Verification
The assertions assume three things about the inputs. `byte_tick` is a single-cycle pulse. A host write never lands in the same cycle as a `byte_tick`, because the tick consumes the register before the write is counted. `start` and `cancel` are never raised together. The bench produces a tick every fourth cycle, and its host model writes only in cycles without a tick, one cycle after it sees `drq`. It raises `start` and `cancel` only in separate tasks. The scenarios cover a missing first byte, a deliberately skipped payload byte, both mark values, all length corners and a cancel in the middle of the gap.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LEAD, ST_WINDOW, ST_PAD, ST_MARK,
    ST_DATA, ST_CRC_HI, ST_CRC_LO, ST_TAIL
  } sws_state_e;

  localparam logic [7:0]  SWS_FILL     = 8'h00;
  localparam logic [7:0]  SWS_SYNC     = 8'hA1;
  localparam logic [7:0]  SWS_MARK_STD = 8'hFB;
  localparam logic [7:0]  SWS_MARK_DEL = 8'hF8;
  localparam logic [7:0]  SWS_TRAILER  = 8'hFE;
  localparam logic [15:0] SWS_POLY     = 16'h1021;
  localparam logic [15:0] SWS_INIT     = 16'hFFFF;

  // One byte of CRC-16, most significant bit first.
  function automatic logic [15:0] sws_crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = (r << 1) ^ SWS_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/sws_crc16.sv
module sws_crc16
  import sws_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        preset,
  input  logic        update,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  // Value the register holds after three sync bytes from the initial value.
  localparam logic [15:0] SYNC_PRESET =
    sws_crc_step(sws_crc_step(sws_crc_step(SWS_INIT, SWS_SYNC), SWS_SYNC), SWS_SYNC);

  logic [15:0] crc_q, crc_d;
  logic        crc_en;

  always_comb begin
    crc_en = preset | update;
    crc_d  = preset ? SYNC_PRESET : sws_crc_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= SWS_INIT;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc = crc_q;

  // R8: the preset lands on the well-known CCITT value after A1 A1 A1.
  p_sync_preset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (crc_q == 16'hCDB4))
    else $error("crc preset wrong");
endmodule

// File: rtl/sws_host_port.sv
module sws_host_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       raise,
  input  logic       drop,
  input  logic       consume,
  output logic       drq,
  output logic       written,
  output logic [7:0] data
);
  logic       drq_q, drq_d;
  logic       wrt_q, wrt_d;
  logic [7:0] data_q;

  always_comb begin
    wrt_d = consume ? 1'b0 : ((wr && drq_q) ? 1'b1 : wrt_q);
    if (raise)                      drq_d = 1'b1;
    else if (drop || (wr && drq_q)) drq_d = 1'b0;
    else                            drq_d = drq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drq_q <= 1'b0;
      wrt_q <= 1'b0;
    end else begin
      drq_q <= drq_d;
      wrt_q <= wrt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  data_q <= '0;
    else if (wr) data_q <= wdata;
  end

  assign drq     = drq_q;
  assign written = wrt_q;
  assign data    = data_q;

  // R6: a host write answered the request, so it must fall unless re-raised.
  p_wr_clears_drq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && drq_q && !raise) |=> !drq_q)
    else $error("drq not cleared by host write");
endmodule

// File: rtl/sector_write_seq.sv
module sector_write_seq
  import sws_pkg::*;
#(
  parameter int LEAD_TICKS   = 9,
  parameter int WINDOW_TICKS = 8,
  parameter int PAUSE_TICKS  = 12,
  parameter int ZERO_BYTES   = 12,
  parameter int SYNC_BYTES   = 3,
  parameter int BASE_LEN     = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_tick,
  input  logic       start,
  input  logic       cancel,
  input  logic       deleted_mark,
  input  logic       multi_sector,
  input  logic [1:0] size_code,
  input  logic       host_wr,
  input  logic [7:0] host_data,
  output logic       drq,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       busy,
  output logic       lost_data,
  output logic       done,
  output logic       next_sector
);
  localparam int CNT_W = $clog2((BASE_LEN << 3) + 1);
  localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_TICKS - 1);
  localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WINDOW_TICKS - 1);
  localparam logic [CNT_W-1:0] PAD_FIRST = CNT_W'(PAUSE_TICKS - 1);
  localparam logic [CNT_W-1:0] ZERO_END  = CNT_W'(PAUSE_TICKS - 1 + ZERO_BYTES);
  localparam logic [CNT_W-1:0] PAD_LAST  = CNT_W'(PAUSE_TICKS - 2 + ZERO_BYTES + SYNC_BYTES);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  sws_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, rem_after, len_q;
  logic             mark_q, multi_q, lost_q, lost_d;
  logic [7:0]       hold_q, hold_nx, emit_byte;
  logic             hold_ld, emit, raise, drop, consume, crc_preset, crc_upd;
  logic             fin, adv, lost_set;
  logic             drq_w, written_w;
  logic [7:0]       reg_data;
  logic [15:0]      crc_w;

  sws_host_port u_host (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .wdata(host_data),
    .raise(raise), .drop(drop), .consume(consume),
    .drq(drq_w), .written(written_w), .data(reg_data)
  );

  sws_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .preset(crc_preset), .update(crc_upd),
    .din(emit_byte), .crc(crc_w)
  );

  assign rem_after = cnt_q - ONE;

  // Next-state logic
  always_comb begin
    state_d = state_q;   cnt_d = cnt_q;
    emit = 1'b0;         emit_byte = SWS_FILL;
    raise = 1'b0;        drop = 1'b0;        consume = 1'b0;
    crc_preset = 1'b0;   crc_upd = 1'b0;
    hold_ld = 1'b0;      hold_nx = SWS_FILL;
    fin = 1'b0;          adv = 1'b0;         lost_set = 1'b0;
    if (cancel) begin
      state_d = ST_IDLE;
      drop    = 1'b1;
    end else if (start) begin
      state_d = ST_LEAD;
      cnt_d   = '0;
      drop    = 1'b1;
      consume = 1'b1;
    end else if (byte_tick) begin
      unique case (state_q)
        ST_LEAD: begin
          cnt_d = cnt_q + ONE;
          if (cnt_q == LEAD_LAST) begin
            state_d = ST_WINDOW;  cnt_d = '0;  raise = 1'b1;
          end
        end
        ST_WINDOW: begin
          cnt_d = cnt_q + ONE;
          if (cnt_q == WIN_LAST) begin
            drop  = 1'b1;
            cnt_d = '0;
            if (written_w) state_d = ST_PAD;
            else begin
              state_d = ST_IDLE;  lost_set = 1'b1;  fin = 1'b1;
            end
          end
        end
        ST_PAD: begin
          cnt_d = cnt_q + ONE;
          if (cnt_q >= PAD_FIRST) begin
            emit      = 1'b1;
            emit_byte = (cnt_q < ZERO_END) ? SWS_FILL : SWS_SYNC;
          end
          if (cnt_q == PAD_LAST) begin
            state_d = ST_MARK;  crc_preset = 1'b1;
          end
        end
        ST_MARK: begin
          emit      = 1'b1;
          emit_byte = mark_q ? SWS_MARK_DEL : SWS_MARK_STD;
          crc_upd   = 1'b1;
          hold_ld   = 1'b1;
          hold_nx   = reg_data;
          consume   = 1'b1;
          raise     = 1'b1;
          cnt_d     = len_q;
          state_d   = ST_DATA;
        end
        ST_DATA: begin
          emit      = 1'b1;
          emit_byte = hold_q;
          crc_upd   = 1'b1;
          cnt_d     = rem_after;
          if (rem_after != '0) begin
            hold_ld  = 1'b1;
            hold_nx  = written_w ? reg_data : SWS_FILL;
            lost_set = !written_w;
            consume  = 1'b1;
            if (rem_after != ONE) raise = 1'b1;
            else                  drop  = 1'b1;
          end else begin
            drop    = 1'b1;
            state_d = ST_CRC_HI;
          end
        end
        ST_CRC_HI: begin
          emit = 1'b1;  emit_byte = crc_w[15:8];  state_d = ST_CRC_LO;
        end
        ST_CRC_LO: begin
          emit = 1'b1;  emit_byte = crc_w[7:0];   state_d = ST_TAIL;
        end
        ST_TAIL: begin
          emit = 1'b1;  emit_byte = SWS_TRAILER;  state_d = ST_IDLE;
          adv  = multi_q;
          fin  = !multi_q;
        end
        default: ;
      endcase
    end
    lost_d = start ? 1'b0 : (lost_set ? 1'b1 : lost_q);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lost_q  <= lost_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q  <= 1'b0;
      multi_q <= 1'b0;
      len_q   <= '0;
    end else if (start && !cancel) begin
      mark_q  <= deleted_mark;
      multi_q <= multi_sector;
      len_q   <= CNT_W'(BASE_LEN << size_code);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_ld) hold_q <= hold_nx;
  end

  assign drq         = drq_w;
  assign out_valid   = emit;
  assign out_byte    = emit_byte;
  assign busy        = (state_q != ST_IDLE);
  assign lost_data   = lost_q;
  assign done        = fin;
  assign next_sector = adv;

  // R4: bytes leave only on byte times.
  p_valid_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> byte_tick)
    else $error("output without tick");
  // R2: the request belongs to an active sequence.
  p_drq_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drq |-> busy)
    else $error("drq while idle");
  // R8: no request during CRC and trailer.
  p_tail_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_CRC_HI, ST_CRC_LO, ST_TAIL}) |-> !drq)
    else $error("drq during tail");
  // R9: command end leaves the block idle.
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || next_sector) |=> !busy)
    else $error("busy after end");
  // R10: cancel stops the sequence on the next cycle.
  p_cancel_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!busy && !drq))
    else $error("cancel ignored");
  // R5: the remaining count never exceeds the configured length.
  p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (cnt_q <= len_q && cnt_q != '0))
    else $error("payload count out of range");
endmodule

// File: tb/tb_sector_write_seq.sv
module tb_sector_write_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk, rst_n, byte_tick, start, cancel, deleted_mark, multi_sector;
  logic [1:0] size_code;
  logic       host_wr;
  logic [7:0] host_data;
  logic       drq, out_valid, busy, lost_data, done, next_sector;
  logic [7:0] out_byte;

  sector_write_seq dut (
    .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick), .start(start), .cancel(cancel),
    .deleted_mark(deleted_mark), .multi_sector(multi_sector), .size_code(size_code),
    .host_wr(host_wr), .host_data(host_data), .drq(drq), .out_valid(out_valid),
    .out_byte(out_byte), .busy(busy), .lost_data(lost_data), .done(done),
    .next_sector(next_sector)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  // host model settings, written only by tasks
  bit         resp_en = 0, resp_clr = 0;
  int         skip_idx = -1;
  logic [7:0] seed = 8'h00;
  int         len_exp = 128;

  function automatic logic [7:0] pat(input int k, input logic [7:0] s);
    return 8'(k * 37) ^ s;
  endfunction

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] v;
    v = c;
    for (int i = 7; i >= 0; i--) begin
      v = {v[14:0], 1'b0} ^ ((v[15] ^ b[i]) ? 16'h1021 : 16'h0000);
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // tick generator and host responder
  int tdiv = 0, k = 0;
  bit hold = 0, wr_prev = 0;
  initial begin
    byte_tick = 0; host_wr = 0; host_data = 0;
  end
  always @(negedge clk) begin
    byte_tick = (tdiv == TICK_DIV - 1);
    tdiv      = (tdiv + 1) % TICK_DIV;
    host_wr   = 0;
    if (resp_clr) begin
      k = 0; hold = 0;
    end else if (hold) begin
      if (byte_tick) begin hold = 0; k++; end
    end else if (resp_en && drq && !byte_tick && !wr_prev) begin
      if (k == skip_idx) hold = 1;
      else begin
        host_wr = 1; host_data = pat(k, seed); k++;
      end
    end
    wr_prev = host_wr;
  end

  // output monitor
  logic [7:0] cap [0:1199];
  int cap_n, ticks, first_drq, first_out, done_tick, done_n, next_n, rises, tail_bad;
  bit drq_prev;
  always @(negedge clk) begin
    #1;
    if (start) begin
      cap_n = 0; ticks = 0; first_drq = -1; first_out = -1; done_tick = -1;
      done_n = 0; next_n = 0; rises = 0; tail_bad = 0; drq_prev = 0;
    end else begin
      if (drq && first_drq < 0) first_drq = ticks;
      if (drq && !drq_prev) rises++;
      if (out_valid) begin
        if (first_out < 0) first_out = ticks + 1;
        if (cap_n >= 16 + len_exp && drq) tail_bad++;
        if (cap_n < 1200) cap[cap_n] = out_byte;
        cap_n++;
      end
      if (done) begin done_n++; done_tick = ticks + 1; end
      if (next_sector) next_n++;
      if (byte_tick) ticks++;
      drq_prev = drq;
    end
  end

  task automatic launch(input logic del, input logic multi, input logic [1:0] sz,
                        input int skip, input logic [7:0] sd, input bit respond);
    @(posedge clk); #1;
    resp_clr = 1; resp_en = respond; skip_idx = skip; seed = sd;
    len_exp = 128 << sz;
    @(posedge clk); #1;
    resp_clr = 0;
    deleted_mark = del; multi_sector = multi; size_code = sz; start = 1;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000 && (done_n + next_n) == 0; i++) @(posedge clk);
    repeat (8) @(posedge clk);
  endtask

  task automatic verify_stream(input logic del, input int skip, input logic [7:0] sd);
    int n, bad_pre, bad_dat, first_bad;
    logic [7:0] e, m;
    logic [15:0] c;
    n = len_exp;
    check(cap_n == 19 + n, "R5 sector byte count", cap_n, 19 + n);
    bad_pre = 0;
    for (int i = 0; i < 15; i++) begin
      e = (i < 12) ? 8'h00 : 8'hA1;
      if (cap[i] !== e) bad_pre++;
    end
    check(bad_pre == 0, "R4 gap and sync bytes", bad_pre, 0);
    m = del ? 8'hF8 : 8'hFB;
    check(cap[15] === m, "R4 data mark", cap[15], m);
    c = 16'hFFFF;
    for (int i = 0; i < 3; i++) c = ref_crc(c, 8'hA1);
    c = ref_crc(c, m);
    bad_dat = 0; first_bad = -1;
    for (int j = 0; j < n; j++) begin
      e = (j == skip) ? 8'h00 : pat(j, sd);
      c = ref_crc(c, e);
      if (cap[16 + j] !== e) begin
        bad_dat++;
        if (first_bad < 0) first_bad = j;
      end
    end
    check(bad_dat == 0, (skip >= 0) ? "R7 zero-filled payload" : "R6 payload order",
          first_bad, -1);
    check(cap[16 + n] === c[15:8], "R8 crc high", cap[16 + n], c[15:8]);
    check(cap[17 + n] === c[7:0], "R8 crc low", cap[17 + n], c[7:0]);
    check(cap[18 + n] === 8'hFE, "R8 trailer", cap[18 + n], 8'hFE);
    check(tail_bad == 0, "R8 drq low in tail", tail_bad, 0);
  endtask

  task automatic t_reset();
    #1;
    check(drq == 0 && busy == 0 && out_valid == 0, "R1 idle outputs", {drq, busy, out_valid}, 0);
    check(done == 0 && next_sector == 0 && lost_data == 0, "R1 flags", {done, next_sector, lost_data}, 0);
  endtask

  task automatic t_basic();
    launch(1'b0, 1'b0, 2'd0, -1, 8'h5A, 1);
    wait_end();
    check(first_drq == 9, "R2 first drq tick", first_drq, 9);
    check(first_out == 29, "R4 first byte tick", first_out, 29);
    check(rises == 128, "R6 drq request count", rises, 128);
    verify_stream(1'b0, -1, 8'h5A);
    check(done_n == 1 && next_n == 0, "R9 done single", done_n * 10 + next_n, 10);
    check(done_tick == first_out + 18 + 128, "R9 done on trailer", done_tick, first_out + 146);
    check(lost_data == 0 && busy == 0, "R7 no loss, idle", {lost_data, busy}, 0);
  endtask

  task automatic t_deleted_multi();
    launch(1'b1, 1'b1, 2'd1, -1, 8'hC3, 1);
    wait_end();
    verify_stream(1'b1, -1, 8'hC3);
    check(next_n == 1 && done_n == 0, "R9 next_sector for multi", next_n * 10 + done_n, 10);
  endtask

  task automatic t_lost_first();
    launch(1'b0, 1'b0, 2'd0, -1, 8'h11, 0);
    wait_end();
    check(done_n == 1 && done_tick == 17, "R3 abort tick", done_tick, 17);
    check(lost_data == 1, "R3 lost set", lost_data, 1);
    check(cap_n == 0, "R3 nothing emitted", cap_n, 0);
    check(drq == 0 && busy == 0, "R3 idle after abort", {drq, busy}, 0);
  endtask

  task automatic t_zero_fill();
    launch(1'b0, 1'b0, 2'd0, 5, 8'h77, 1);
    wait_end();
    verify_stream(1'b0, 5, 8'h77);
    check(lost_data == 1, "R7 lost after missing byte", lost_data, 1);
  endtask

  task automatic t_cancel();
    int n0;
    launch(1'b0, 1'b0, 2'd0, -1, 8'h22, 1);
    wait (cap_n == 6);
    @(posedge clk); #1; cancel = 1;
    @(posedge clk); #1; cancel = 0;
    #(CLK_PERIOD);
    n0 = cap_n;
    repeat (80) @(posedge clk);
    #(CLK_PERIOD/2 + 2);
    check(cap_n == n0, "R10 no output after cancel", cap_n, n0);
    check(busy == 0 && drq == 0, "R10 idle after cancel", {busy, drq}, 0);
    check(done_n == 0, "R10 no done", done_n, 0);
    check(n0 >= 6 && cap[0] == 8'h00, "R10 emitted bytes kept", n0, 6);
  endtask

  task automatic t_max_len();
    launch(1'b0, 1'b0, 2'd3, -1, 8'h9C, 1);
    wait_end();
    verify_stream(1'b0, -1, 8'h9C);
    check(lost_data == 0, "R7 lost cleared by start", lost_data, 0);
  endtask

  initial begin
    rst_n = 0; start = 0; cancel = 0; deleted_mark = 0; multi_sector = 0; size_code = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);
    t_reset();
    t_basic();
    t_deleted_multi();
    t_lost_first();
    t_zero_fill();
    t_cancel();
    t_max_len();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule